// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a synchronous 4096-word by 16-bit memory with two fully independent access ports, called left and right. Either port can read or write any word in any cycle. Each port has an active-low select, a write-select line (low means write), an active-low read enable and a 12-bit word address. Write data and read data are carried on separate buses.

The two highest words double as mailboxes between the ports. The top word (0xFFF) carries messages from left to right. The word below it (0xFFE) carries messages from right to left. When a port writes its outbound mailbox, the other port's active-low interrupt falls. When the receiving port reads that word, its interrupt is released. Each port also has an active-low busy input, driven by external arbitration logic. While a port's busy input is low, that port's accesses cannot change any flag.

The mailbox words still store data. A message is therefore written and then picked up by the reader in the same access that acknowledges it.

Top module: `mailbox_dpram`

## Requirements
- R1: A port writes `wdata` into the word at its address when its select is low and its write-select is low. A port reads when its select is low, its write-select is high and its read enable is low; the word then appears on its `rdata` after that clock edge. In every other cycle, `rdata` holds its value.
- R2: A clock edge with `rst_n` low drives both interrupt outputs high.
- R3: A left write to 0xFFF drives `r_irq_n` low after the edge. A right write to 0xFFE drives `l_irq_n` low after the edge.
- R4: A right read of 0xFFF drives `r_irq_n` high after the edge. A left read of 0xFFE drives `l_irq_n` high after the edge.
- R5: None of these accesses changes a flag:
  - an access with the select high;
  - a read with the read enable high;
  - a port reading its own outbound mailbox.
- R6: While the busy input of the port doing a set or a clear is low, that access leaves the flag unchanged.
- R7: Writes to 0xFFF and 0xFFE store their data like any other word. A blocked write (select high) stores nothing.
- R8: When both ports write the same address in one cycle, the word keeps the left port's data.
- R9: A read of a word that the other port writes in the same cycle returns the data held before that write.
- R10: When a set and a clear of the same flag fall in one cycle, the flag ends up set (interrupt low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write-select, low = write |
| l_oe_n | input | 1 | Left read enable, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_busy_n | input | 1 | Left busy, active low |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write-select, low = write |
| r_oe_n | input | 1 | Right read enable, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_busy_n | input | 1 | Right busy, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Two activities can meet in one cycle. In the first, one port posts a mailbox message while the receiving port reads that same word, so a set and a clear of one flag coincide. The bench provokes this on both flags. It expects the interrupt to stay asserted and the reader to receive the word as it stood before the write. In the second, a plain word is written by one port while the other port reads it, or both ports write it. Here the bench expects the old data on the read and the left port's data in the word afterwards.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  // Write request: port selected and write-select low.
  function automatic logic wr_req(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  // Read request: port selected, write-select high, read enable low.
  function automatic logic rd_req(input logic cs_n, input logic we_n,
                                  input logic oe_n);
    return !cs_n && we_n && !oe_n;
  endfunction

  // Next pending state of a mailbox flag; a set outranks a clear.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
`timescale 1ns/1ps
module mbx_port_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OUT_BOX = '1,
  parameter logic [ADDR_W-1:0] IN_BOX = '0
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output logic              wr_en,
  output logic              rd_en,
  output logic              post_peer,
  output logic              ack_own
);
  import mbx_pkg::*;

  always_comb begin
    wr_en     = wr_req(cs_n, we_n);
    rd_en     = rd_req(cs_n, we_n, oe_n);
    post_peer = wr_en && (addr == OUT_BOX) && busy_n;
    ack_own   = rd_en && (addr == IN_BOX) && busy_n;
  end

endmodule

// File: rtl/mbx_storage.sv
`timescale 1ns/1ps
module mbx_storage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // The left write is placed last, so it wins on an address clash.
  // Reads sample the array before this edge's writes land.
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
    if (l_rd) l_rdata <= mem[l_addr];
    if (r_rd) r_rdata <= mem[r_addr];
  end

endmodule

// File: rtl/mbx_flag.sv
`timescale 1ns/1ps
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  import mbx_pkg::*;

  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= flag_next(pending, set, clr);
  end

  assign irq_n = !pending;

endmodule

// File: rtl/mailbox_dpram.sv
`timescale 1ns/1ps
module mailbox_dpram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_n,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_n,
  output logic              r_irq_n
);
  // Top word: left-to-right mailbox. Word below: right-to-left mailbox.
  localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
  localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

  // Named internal events, observed by the bound checker.
  logic l_wr, l_rd, r_wr, r_rd;
  logic set_r_flag, clr_r_flag, set_l_flag, clr_l_flag;

  mbx_port_decode #(.ADDR_W(ADDR_W), .OUT_BOX(BOX_TO_R), .IN_BOX(BOX_TO_L))
  u_dec_l (
    .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n), .addr(l_addr),
    .busy_n(l_busy_n), .wr_en(l_wr), .rd_en(l_rd),
    .post_peer(set_r_flag), .ack_own(clr_l_flag)
  );

  mbx_port_decode #(.ADDR_W(ADDR_W), .OUT_BOX(BOX_TO_L), .IN_BOX(BOX_TO_R))
  u_dec_r (
    .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n), .addr(r_addr),
    .busy_n(r_busy_n), .wr_en(r_wr), .rd_en(r_rd),
    .post_peer(set_l_flag), .ack_own(clr_r_flag)
  );

  mbx_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata)
  );

  mbx_flag u_flag_r (
    .clk(clk), .rst_n(rst_n), .set(set_r_flag), .clr(clr_r_flag),
    .irq_n(r_irq_n)
  );

  mbx_flag u_flag_l (
    .clk(clk), .rst_n(rst_n), .set(set_l_flag), .clr(clr_l_flag),
    .irq_n(l_irq_n)
  );

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker (
  input logic clk,
  input logic rst_n,
  input logic l_oe_n,
  input logic r_oe_n,
  input logic l_irq_n,
  input logic r_irq_n,
  input logic set_r_flag,
  input logic clr_r_flag,
  input logic set_l_flag,
  input logic clr_l_flag
);

  assert_reset_release_R2: assert property (@(posedge clk)
    !rst_n |=> (l_irq_n && r_irq_n));

  assert_post_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_r_flag |=> !r_irq_n);

  assert_post_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_l_flag |=> !l_irq_n);

  assert_ack_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r_flag && !set_r_flag) |=> r_irq_n);

  assert_ack_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l_flag && !set_l_flag) |=> l_irq_n);

  assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r_flag && !clr_r_flag) |=> $stable(r_irq_n));

  assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_l_flag && !clr_l_flag) |=> $stable(l_irq_n));

  assert_no_ack_without_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_oe_n && l_oe_n) |=> !$rose(r_irq_n) && !$rose(l_irq_n));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r_flag && clr_r_flag) |=> !r_irq_n);

endmodule

bind mailbox_dpram mbx_checker u_mbx_checker (
  .clk(clk), .rst_n(rst_n), .l_oe_n(l_oe_n), .r_oe_n(r_oe_n),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n),
  .set_r_flag(set_r_flag), .clr_r_flag(clr_r_flag),
  .set_l_flag(set_l_flag), .clr_l_flag(clr_l_flag)
);

// File: tb/mailbox_dpram_bench.sv
`timescale 1ns/1ps
module mailbox_dpram_bench;
  localparam int AW = 12;
  localparam int DW = 16;

  // Port operations used by the vectors.
  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_RDNO = 3'd3; // selected read, read enable high
  localparam logic [2:0] OP_WRNS = 3'd4; // write with select high

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    lop;
    logic [AW-1:0] la;
    logic [DW-1:0] lwd;
    logic          lb;
    logic [2:0]    rop;
    logic [AW-1:0] ra;
    logic [DW-1:0] rwd;
    logic          rb;
    logic          chk_l;
    logic [DW-1:0] exp_l;
    logic          chk_r;
    logic [DW-1:0] exp_r;
    logic          exp_li;
    logic          exp_ri;
  } vec_t;

  function automatic vec_t mk(
    input logic [3:0] req,
    input logic [2:0] lop, input logic [AW-1:0] la, input logic [DW-1:0] lwd,
    input logic lb,
    input logic [2:0] rop, input logic [AW-1:0] ra, input logic [DW-1:0] rwd,
    input logic rb,
    input logic cl, input logic [DW-1:0] el,
    input logic cr, input logic [DW-1:0] er,
    input logic eli, input logic eri);
    vec_t v;
    v.req = req; v.lop = lop; v.la = la; v.lwd = lwd; v.lb = lb;
    v.rop = rop; v.ra = ra; v.rwd = rwd; v.rb = rb;
    v.chk_l = cl; v.exp_l = el; v.chk_r = cr; v.exp_r = er;
    v.exp_li = eli; v.exp_ri = eri;
    return v;
  endfunction

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    mk(1,  OP_WR,  12'h005, 16'hA5A5, 1, OP_IDLE, 12'h000, 16'h0000, 1, 0, 16'h0000, 0, 16'h0000, 1, 1), // R1 write
    mk(1,  OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'h005, 16'h0000, 1, 0, 16'h0000, 1, 16'hA5A5, 1, 1), // R1 read
    mk(3,  OP_WR,  12'hFFF, 16'h1234, 1, OP_IDLE, 12'h000, 16'h0000, 1, 0, 16'h0000, 0, 16'h0000, 1, 0), // R3 post to right
    mk(5,  OP_RD,  12'hFFF, 16'h0000, 1, OP_IDLE, 12'h000, 16'h0000, 1, 1, 16'h1234, 0, 16'h0000, 1, 0), // R5 sender reads own box
    mk(5,  OP_IDLE,12'h000, 16'h0000, 1, OP_RDNO, 12'hFFF, 16'h0000, 1, 0, 16'h0000, 0, 16'h0000, 1, 0), // R5 read enable high
    mk(6,  OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'hFFF, 16'h0000, 0, 0, 16'h0000, 1, 16'h1234, 1, 0), // R6 busy blocks clear
    mk(4,  OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'hFFF, 16'h0000, 1, 0, 16'h0000, 1, 16'h1234, 1, 1), // R4 R7 clear + data
    mk(5,  OP_WRNS,12'hFFF, 16'h9999, 1, OP_IDLE, 12'h000, 16'h0000, 1, 0, 16'h0000, 0, 16'h0000, 1, 1), // R5 select high
    mk(7,  OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'hFFF, 16'h0000, 1, 0, 16'h0000, 1, 16'h1234, 1, 1), // R7 nothing stored
    mk(6,  OP_IDLE,12'h000, 16'h0000, 1, OP_WR,   12'hFFE, 16'hBEEF, 0, 0, 16'h0000, 0, 16'h0000, 1, 1), // R6 busy blocks set
    mk(3,  OP_IDLE,12'h000, 16'h0000, 1, OP_WR,   12'hFFE, 16'hBEEF, 1, 0, 16'h0000, 0, 16'h0000, 0, 1), // R3 post to left
    mk(6,  OP_RD,  12'hFFE, 16'h0000, 0, OP_IDLE, 12'h000, 16'h0000, 1, 1, 16'hBEEF, 0, 16'h0000, 0, 1), // R6 busy blocks clear
    mk(4,  OP_RD,  12'hFFE, 16'h0000, 1, OP_IDLE, 12'h000, 16'h0000, 1, 1, 16'hBEEF, 0, 16'h0000, 1, 1), // R4 left clear
    mk(8,  OP_WR,  12'h010, 16'h1111, 1, OP_WR,   12'h010, 16'h2222, 1, 0, 16'h0000, 0, 16'h0000, 1, 1), // R8 clash
    mk(8,  OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'h010, 16'h0000, 1, 0, 16'h0000, 1, 16'h1111, 1, 1), // R8 left won
    mk(9,  OP_IDLE,12'h000, 16'h0000, 1, OP_WR,   12'h020, 16'h7777, 1, 0, 16'h0000, 0, 16'h0000, 1, 1), // R9 prefill
    mk(9,  OP_WR,  12'h020, 16'h3333, 1, OP_RD,   12'h020, 16'h0000, 1, 0, 16'h0000, 1, 16'h7777, 1, 1), // R9 old data
    mk(9,  OP_RD,  12'h020, 16'h0000, 1, OP_IDLE, 12'h000, 16'h0000, 1, 1, 16'h3333, 0, 16'h0000, 1, 1), // R9 new data
    mk(10, OP_WR,  12'hFFF, 16'h5555, 1, OP_RD,   12'hFFF, 16'h0000, 1, 0, 16'h0000, 1, 16'h1234, 1, 0), // R10 right flag
    mk(10, OP_IDLE,12'h000, 16'h0000, 1, OP_RD,   12'hFFF, 16'h0000, 1, 0, 16'h0000, 1, 16'h5555, 1, 1), // R10 then cleared
    mk(10, OP_RD,  12'hFFE, 16'h0000, 1, OP_WR,   12'hFFE, 16'h6666, 1, 1, 16'hBEEF, 0, 16'h0000, 0, 1), // R10 left flag
    mk(4,  OP_RD,  12'hFFE, 16'h0000, 1, OP_IDLE, 12'h000, 16'h0000, 1, 1, 16'h6666, 0, 16'h0000, 1, 1)  // R4 R7 left clear
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_busy_n = 1'b1;
  logic r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_busy_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mailbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u_mailbox_dpram (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
  );

  task automatic check(input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ctl(input logic [2:0] op); // {cs_n, we_n, oe_n}
    case (op)
      OP_WR:   return 3'b001;
      OP_RD:   return 3'b010;
      OP_RDNO: return 3'b011;
      OP_WRNS: return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  // Drive after a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input vec_t v);
    {l_cs_n, l_we_n, l_oe_n} = ctl(v.lop);
    {r_cs_n, r_we_n, r_oe_n} = ctl(v.rop);
    l_addr = v.la; l_wdata = v.lwd; l_busy_n = v.lb;
    r_addr = v.ra; r_wdata = v.rwd; r_busy_n = v.rb;
    @(posedge clk);
    @(negedge clk);
    {l_cs_n, l_we_n, l_oe_n} = 3'b111;
    {r_cs_n, r_we_n, r_oe_n} = 3'b111;
    l_busy_n = 1'b1; r_busy_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: interrupts released by reset
    check(2, "l_irq_n after reset", {15'd0, l_irq_n}, 16'd1);
    check(2, "r_irq_n after reset", {15'd0, r_irq_n}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i]);
      check(VEC[i].req, $sformatf("vec %0d l_irq_n", i), {15'd0, l_irq_n}, {15'd0, VEC[i].exp_li});
      check(VEC[i].req, $sformatf("vec %0d r_irq_n", i), {15'd0, r_irq_n}, {15'd0, VEC[i].exp_ri});
      if (VEC[i].chk_l) check(VEC[i].req, $sformatf("vec %0d l_rdata", i), l_rdata, VEC[i].exp_l);
      if (VEC[i].chk_r) check(VEC[i].req, $sformatf("vec %0d r_rdata", i), r_rdata, VEC[i].exp_r);
    end

    // R1: rdata holds while no read happens
    step(mk(1, OP_WR, 12'h030, 16'hCAFE, 1, OP_IDLE, 12'h000, 16'h0, 1, 0, 16'h0, 0, 16'h0, 1, 1));
    check(1, "l_rdata hold after write", l_rdata, 16'h6666);

    // R2: reset with both flags pending
    step(mk(3, OP_WR, 12'hFFF, 16'h0001, 1, OP_WR, 12'hFFE, 16'h0002, 1, 0, 16'h0, 0, 16'h0, 0, 0));
    check(3, "both flags set l_irq_n", {15'd0, l_irq_n}, 16'd0);
    check(3, "both flags set r_irq_n", {15'd0, r_irq_n}, 16'd0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(2, "l_irq_n after mid-run reset", {15'd0, l_irq_n}, 16'd1);
    check(2, "r_irq_n after mid-run reset", {15'd0, r_irq_n}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: mailbox words still hold data after the reset
    step(mk(7, OP_RD, 12'hFFE, 16'h0, 1, OP_RD, 12'hFFF, 16'h0, 1, 1, 16'h0002, 1, 16'h0001, 1, 1));
    check(7, "l_rdata mailbox data", l_rdata, 16'h0002);
    check(7, "r_rdata mailbox data", r_rdata, 16'h0001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule